// File: doc/BRIEF.md
# Touch Panel Coordinate Sampler

This block is the host-side master that collects pen positions from an external resistive-panel converter over a four-signal serial link (chip select, serial clock, data out, data in). It waits in idle until the converter's active-low pen interrupt line reports a touch. It then runs a series of 24-clock frames in SPI mode 0. Each frame holds one command byte followed by two zero bytes, and the conversion result returns in the second and third received bytes.

For each axis the block repeats conversions at the same channel address, with a ratiometric (differential) reference, until two successive readings agree within a programmable tolerance. The X axis goes first and the Y axis second. A programmable retry limit caps the number of conversions per axis; reaching it without agreement abandons the sample. Every sequence ends with one more frame that asks the converter to power down. After that frame the block gives a single-cycle strobe: either a valid strobe with the X/Y pair, or an error strobe.

The serial clock rate is set by a divider counted in system clocks. The pen line goes through a synchronizer and is looked at only while the block is idle.

Top module: `tsc_sampler`

## Requirements
- R1: SCLK idles low and rises only while cs_n is low. Each frame (cs_n low interval) has exactly 24 SCLK rising edges. MOSI changes only while SCLK is low, either at an SCLK falling edge or when cs_n falls. MISO is captured at SCLK rising edges.
- R2: Every SCLK high phase and low phase lasts exactly cfg_div+1 system clocks. The first rising edge comes cfg_div+1 clocks after cs_n falls, and cs_n rises cfg_div+1 clocks after the last falling edge.
- R3: The command byte goes out MSB first. Bit 7 is 1 (start marker) and bits 6:4 are the channel address (101 for X, 001 for Y). Bit 3 is the resolution (0 means 12-bit), bit 2 is the reference mode (always 0, differential) and bits 1:0 are the power field (11 for settling frames, 00 for the closing frame). The second and third MOSI bytes are all zero.
- R4: The 12-bit reading is the MISO bits captured on rising edges 9 to 20 of the frame, MSB first: the whole second byte followed by the upper nibble of the third.
- R5: No frame starts while the synchronized pen line is high. A sequence starts from idle when it is low. Pen line changes after the sequence has started do not alter it, and a pen line held high after the outcome starts nothing.
- R6: X is converted first, then Y. An axis is settled when a reading differs from the previous reading of that axis by at most cfg_tol. The settled value is the later reading of the agreeing pair.
- R7: If a comparison fails on an axis that has already used max(cfg_max_tries, 2) conversions, the sequence is abandoned: Y is not converted and coord_err pulses instead of coord_valid.
- R8: Every sequence ends with exactly one closing frame with power field 00, at the address of the last axis converted. After that frame, exactly one of coord_valid or coord_err pulses for a single cycle.
- R9: x_o and y_o change only in the cycle coord_valid is high and hold their values otherwise, including after an error outcome.
- R10: After reset, cs_n is 1, sclk, mosi, coord_valid and coord_err are 0, and x_o and y_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pen_irq_n | input | 1 | Active-low touch indication from the converter (asynchronous) |
| miso | input | 1 | Serial data from the converter |
| cfg_div | input | DIV_W | SCLK half-period minus one, in system clocks |
| cfg_tol | input | RES_W | Largest difference between successive readings that counts as settled |
| cfg_max_tries | input | RETRY_W | Conversion limit per axis (values below 2 act as 2) |
| cs_n | output | 1 | Active-low frame select |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to the converter |
| x_o | output | RES_W | Last settled X reading |
| y_o | output | RES_W | Last settled Y reading |
| coord_valid | output | 1 | One-cycle strobe: x_o/y_o were just updated |
| coord_err | output | 1 | One-cycle strobe: a sample was abandoned at the retry limit |

## Verification
The hardest situation to reach is a sequence that runs right up to the edges of the settling rule. That means readings differing by exactly the tolerance and by one more, an axis that gives up only on its last allowed conversion, and an X failure that must skip Y entirely while the closing frame still appears at the X address. The bench's converter model serves a separate, pre-loaded reading list for each channel address it decodes from the command byte. Directed lists can therefore steer each comparison to these edges, and seeded random lists with chosen spreads cover the space between them. The pen line is toggled at random throughout the settling frames to show that it has no influence once a sequence has begun.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

   localparam int FRAME_BITS = 24;
   localparam int CMD_BITS   = 8;
   localparam int DATA_FIRST = 9;   // first rising edge that carries the reading MSB

   localparam logic [2:0] ADDR_X   = 3'b101;
   localparam logic [2:0] ADDR_Y   = 3'b001;
   localparam logic [1:0] PWR_KEEP = 2'b11;
   localparam logic [1:0] PWR_DOWN = 2'b00;

   typedef enum logic [2:0] {
      S_IDLE,
      S_LAUNCH,
      S_WAIT,
      S_JUDGE,
      S_LAST_LAUNCH,
      S_LAST_WAIT
   } seq_state_t;

   function automatic logic [CMD_BITS-1:0] build_cmd(input logic [2:0] addr,
                                                     input logic       low_res,
                                                     input logic [1:0] pwr);
      return {1'b1, addr, low_res, 1'b0, pwr};
   endfunction

endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else if (STAGES == 1) begin : g_single
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RESET_VAL;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= {STAGES{RESET_VAL}};
            else        r <= {r[STAGES-2:0], d};
         end
         assign q = r[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/tsc_close_enough.sv
module tsc_close_enough #(
   parameter int RES_W = 12
) (
   input  logic [RES_W-1:0] a,
   input  logic [RES_W-1:0] b,
   input  logic [RES_W-1:0] tol,
   output logic             near
);

   logic [RES_W-1:0] gap;

   always_comb begin
      gap  = (a > b) ? (a - b) : (b - a);
      near = (gap <= tol);
   end

endmodule

// File: rtl/tsc_spi_frame.sv
module tsc_spi_frame #(
   parameter int DIV_W      = 8,
   parameter int FRAME_BITS = 24,
   parameter int CAP_FIRST  = 9,
   parameter int CAP_W      = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [FRAME_BITS-1:0] tx_word,
   input  logic [DIV_W-1:0]      half_div,
   input  logic                  miso,
   output logic                  cs_n,
   output logic                  sclk,
   output logic                  mosi,
   output logic                  done,
   output logic [CAP_W-1:0]      rx_field
);

   localparam int EDGE_W = $clog2(2 * FRAME_BITS + 1);
   localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * FRAME_BITS);
   localparam logic [EDGE_W-2:0] CAP_LO    = (EDGE_W-1)'(CAP_FIRST - 1);
   localparam logic [EDGE_W-2:0] CAP_HI    = (EDGE_W-1)'(CAP_FIRST - 1 + CAP_W);

   logic                  busy;
   logic [DIV_W-1:0]      ph;
   logic [EDGE_W-1:0]     edges;
   logic [FRAME_BITS-1:0] sh;
   logic [EDGE_W-2:0]     rise_idx;
   logic                  in_window;

   assign rise_idx  = edges[EDGE_W-1:1];
   assign in_window = (rise_idx >= CAP_LO) && (rise_idx < CAP_HI);
   assign mosi      = sh[FRAME_BITS-1] & ~cs_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cs_n     <= 1'b1;
         sclk     <= 1'b0;
         ph       <= '0;
         edges    <= '0;
         sh       <= '0;
         rx_field <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy  <= 1'b1;
               cs_n  <= 1'b0;
               sclk  <= 1'b0;
               ph    <= '0;
               edges <= '0;
               sh    <= tx_word;
            end
         end else if (ph != half_div) begin
            ph <= ph + DIV_W'(1);
         end else begin
            ph    <= '0;
            edges <= edges + EDGE_W'(1);
            if (edges == LAST_EDGE) begin
               cs_n <= 1'b1;
               busy <= 1'b0;
               done <= 1'b1;
            end else if (!edges[0]) begin
               sclk <= 1'b1;
               if (in_window) rx_field <= {rx_field[CAP_W-2:0], miso};
            end else begin
               sclk <= 1'b0;
               sh   <= {sh[FRAME_BITS-2:0], 1'b0};
            end
         end
      end
   end

endmodule

// File: rtl/tsc_sampler.sv
module tsc_sampler #(
   parameter int DIV_W       = 8,
   parameter int RES_W       = 12,
   parameter int RETRY_W     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pen_irq_n,
   input  logic               miso,
   input  logic [DIV_W-1:0]   cfg_div,
   input  logic [RES_W-1:0]   cfg_tol,
   input  logic [RETRY_W-1:0] cfg_max_tries,
   output logic               cs_n,
   output logic               sclk,
   output logic               mosi,
   output logic [RES_W-1:0]   x_o,
   output logic [RES_W-1:0]   y_o,
   output logic               coord_valid,
   output logic               coord_err
);
   import tsc_pkg::*;

   localparam logic LOW_RES = (RES_W == 8);
   localparam int   PAD_W   = FRAME_BITS - CMD_BITS;

   generate
      if (!(RES_W == 8 || RES_W == 12)) begin : g_bad_res
         $error("tsc_sampler: RES_W must be 8 or 12");
      end
      if (RETRY_W < 2) begin : g_bad_retry
         $error("tsc_sampler: RETRY_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("tsc_sampler: DIV_W must be at least 1");
      end
   endgenerate

   seq_state_t         state;
   logic               pen_q;
   logic               axis_y;
   logic               have_prev;
   logic               failed;
   logic [RETRY_W-1:0] tries;
   logic [RETRY_W-1:0] lim;
   logic [RES_W-1:0]   prev;
   logic [RES_W-1:0]   x_pend;
   logic [RES_W-1:0]   sample;
   logic               near;
   logic               start;
   logic               frame_done;
   logic [FRAME_BITS-1:0] tx_word;
   logic [CMD_BITS-1:0]   cmd;

   tsc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_pen_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pen_irq_n),
      .q     (pen_q)
   );

   always_comb begin
      cmd     = build_cmd(axis_y ? ADDR_Y : ADDR_X, LOW_RES,
                          (state == S_LAST_LAUNCH) ? PWR_DOWN : PWR_KEEP);
      tx_word = {cmd, {PAD_W{1'b0}}};
      start   = (state == S_LAUNCH) || (state == S_LAST_LAUNCH);
      lim     = (cfg_max_tries < RETRY_W'(2)) ? RETRY_W'(2) : cfg_max_tries;
   end

   tsc_spi_frame #(
      .DIV_W      (DIV_W),
      .FRAME_BITS (FRAME_BITS),
      .CAP_FIRST  (DATA_FIRST),
      .CAP_W      (RES_W)
   ) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .tx_word  (tx_word),
      .half_div (cfg_div),
      .miso     (miso),
      .cs_n     (cs_n),
      .sclk     (sclk),
      .mosi     (mosi),
      .done     (frame_done),
      .rx_field (sample)
   );

   tsc_close_enough #(.RES_W(RES_W)) u_near (
      .a    (sample),
      .b    (prev),
      .tol  (cfg_tol),
      .near (near)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         axis_y      <= 1'b0;
         have_prev   <= 1'b0;
         failed      <= 1'b0;
         tries       <= '0;
         prev        <= '0;
         x_pend      <= '0;
         x_o         <= '0;
         y_o         <= '0;
         coord_valid <= 1'b0;
         coord_err   <= 1'b0;
      end else begin
         coord_valid <= 1'b0;
         coord_err   <= 1'b0;
         case (state)
            S_IDLE: begin
               if (!pen_q) begin
                  axis_y    <= 1'b0;
                  have_prev <= 1'b0;
                  failed    <= 1'b0;
                  tries     <= '0;
                  state     <= S_LAUNCH;
               end
            end
            S_LAUNCH: begin
               if (tries != '1) tries <= tries + RETRY_W'(1);
               state <= S_WAIT;
            end
            S_WAIT: begin
               if (frame_done) state <= S_JUDGE;
            end
            S_JUDGE: begin
               if (!have_prev) begin
                  prev      <= sample;
                  have_prev <= 1'b1;
                  state     <= S_LAUNCH;
               end else if (near) begin
                  if (!axis_y) begin
                     x_pend    <= sample;
                     axis_y    <= 1'b1;
                     have_prev <= 1'b0;
                     tries     <= '0;
                     state     <= S_LAUNCH;
                  end else begin
                     prev  <= sample;
                     state <= S_LAST_LAUNCH;
                  end
               end else if (tries >= lim) begin
                  failed <= 1'b1;
                  state  <= S_LAST_LAUNCH;
               end else begin
                  prev  <= sample;
                  state <= S_LAUNCH;
               end
            end
            S_LAST_LAUNCH: state <= S_LAST_WAIT;
            S_LAST_WAIT: begin
               if (frame_done) begin
                  if (failed) begin
                     coord_err <= 1'b1;
                  end else begin
                     coord_valid <= 1'b1;
                     x_o         <= x_pend;
                     y_o         <= prev;
                  end
                  state <= S_IDLE;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/tsc_sampler_chk.sv
module tsc_sampler_chk #(
   parameter int DIV_W = 8,
   parameter int RES_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DIV_W-1:0] cfg_div,
   input logic             cs_n,
   input logic             sclk,
   input logic             mosi,
   input logic [RES_W-1:0] x_o,
   input logic [RES_W-1:0] y_o,
   input logic             coord_valid,
   input logic             coord_err
);

   logic             sclk_d;
   logic             cs_d;
   logic [DIV_W:0]   held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         cs_d   <= 1'b1;
         held   <= '0;
      end else begin
         sclk_d <= sclk;
         cs_d   <= cs_n;
         if ((sclk != sclk_d) || (cs_n != cs_d)) held <= (DIV_W+1)'(1);
         else if (held != '1)                    held <= held + (DIV_W+1)'(1);
      end
   end

   AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> !cs_n);                                                  // R1
   AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !$fell(cs_n) && $changed(mosi)) |-> (!sclk && $past(sclk))); // R1
   AST_CS_FALL_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> !sclk);                                           // R2
   AST_HALF_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && (sclk != sclk_d)) |-> (held == ({1'b0, cfg_div} + (DIV_W+1)'(1)))); // R2
   AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      !(coord_valid && coord_err));                                     // R8
   AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (coord_valid || coord_err) |=> !(coord_valid || coord_err));      // R8
   AST_COORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !coord_valid |-> ($stable(x_o) && $stable(y_o)));                 // R9

endmodule

bind tsc_sampler tsc_sampler_chk #(.DIV_W(DIV_W), .RES_W(RES_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_div     (cfg_div),
   .cs_n        (cs_n),
   .sclk        (sclk),
   .mosi        (mosi),
   .x_o         (x_o),
   .y_o         (y_o),
   .coord_valid (coord_valid),
   .coord_err   (coord_err)
);

// File: tb/tsc_sampler_bench.sv
module tsc_sampler_bench;

   localparam int DIV_W   = 8;
   localparam int RES_W   = 12;
   localparam int RETRY_W = 4;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               pen_irq_n = 1'b1;
   logic               miso = 1'b0;
   logic [DIV_W-1:0]   cfg_div = '0;
   logic [RES_W-1:0]   cfg_tol = '0;
   logic [RETRY_W-1:0] cfg_max_tries = '0;
   logic               cs_n, sclk, mosi, coord_valid, coord_err;
   logic [RES_W-1:0]   x_o, y_o;

   always #5 clk = ~clk;

   tsc_sampler #(.DIV_W(DIV_W), .RES_W(RES_W), .RETRY_W(RETRY_W)) u_tsc_sampler (
      .clk(clk), .rst_n(rst_n), .pen_irq_n(pen_irq_n), .miso(miso),
      .cfg_div(cfg_div), .cfg_tol(cfg_tol), .cfg_max_tries(cfg_max_tries),
      .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .x_o(x_o), .y_o(y_o),
      .coord_valid(coord_valid), .coord_err(coord_err)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   // ---------------- converter model ----------------
   int         xs[16];
   int         ys[16];
   int         xi, yi;
   int         nrise;
   int         nframes;
   int         starts;
   int         bad_frames;
   int         tail_ones;
   bit         in_frame = 1'b0;
   logic [7:0] cb;
   logic [7:0] cmd_log[32];
   logic [11:0] cur_val;

   always @(negedge cs_n) begin
      in_frame = 1'b1;
      nrise    = 0;
      miso     = 1'b0;
      starts++;
   end

   always @(posedge cs_n) begin
      if (in_frame) begin
         if (nrise != 24) bad_frames++;
         if (nframes < 32) cmd_log[nframes] = cb;
         nframes++;
         in_frame = 1'b0;
      end
   end

   always @(posedge sclk) begin
      nrise++;
      if (nrise <= 8) cb = {cb[6:0], mosi};
      else if (mosi) tail_ones++;
      if (nrise == 8) begin
         if (cb[6:4] == 3'b101) begin
            cur_val = (xi < 16) ? 12'(xs[xi]) : 12'd0;
            xi++;
         end else if (cb[6:4] == 3'b001) begin
            cur_val = (yi < 16) ? 12'(ys[yi]) : 12'd0;
            yi++;
         end else begin
            cur_val = 12'd0;
         end
      end
   end

   always @(negedge sclk) begin
      if (in_frame && nrise >= 8 && nrise <= 19) miso = cur_val[11 - (nrise - 8)];
      else                                       miso = 1'b0;
   end

   // ---------------- phase-length monitor ----------------
   int   phase_bad = 0;
   int   held = 1;
   logic p_sclk = 1'b0, p_cs = 1'b1;

   always @(negedge clk) begin
      if (!rst_n) begin
         held = 1; p_sclk = sclk; p_cs = cs_n;
      end else begin
         if (sclk !== p_sclk || cs_n !== p_cs) begin
            if ((sclk !== p_sclk) || (cs_n && !p_cs))
               if (held != int'(cfg_div) + 1) phase_bad++;
            held = 1;
         end else begin
            held++;
         end
         p_sclk = sclk; p_cs = cs_n;
      end
   end

   // ---------------- reference ----------------
   function automatic int clamp12(input int v);
      if (v < 0) return 0;
      if (v > 4095) return 4095;
      return v;
   endfunction

   function automatic void axis_ref(input bit is_y, input int tol, input int maxt,
                                    output int used, output int val, output bit ok);
      int lim, prev, cur, d;
      lim  = (maxt < 2) ? 2 : maxt;
      prev = is_y ? ys[0] : xs[0];
      used = 1; val = 0; ok = 0;
      forever begin
         used++;
         cur = is_y ? ys[used-1] : xs[used-1];
         d   = (cur > prev) ? cur - prev : prev - cur;
         if (d <= tol) begin ok = 1; val = cur; return; end
         if (used >= lim) begin ok = 0; return; end
         prev = cur;
      end
   endfunction

   function automatic void fill_axis(input bit is_y, input int base, input int mode, input int tol);
      int spread, v;
      for (int i = 0; i < 16; i++) begin
         case (mode)
            0:       spread = tol / 2;
            1:       spread = tol + 1 + i % 4;
            2:       spread = 3 * tol + 30;
            default: spread = 200 >> i;
         endcase
         v = clamp12(base + int'($urandom % (2 * spread + 1)) - spread);
         if (is_y) ys[i] = v; else xs[i] = v;
      end
   endfunction

   int prev_x = 0, prev_y = 0;

   task automatic run_trial(input int div, input int tol, input int maxt, input string tag);
      int ux, vx, uy, vy, exp_frames, s0, guard;
      bit okx, oky, exp_ok, got_v, got_e;
      logic [7:0] exp_cmd[32];
      logic [RES_W-1:0] gx, gy;
      axis_ref(1'b0, tol, maxt, ux, vx, okx);
      uy = 0; vy = 0; oky = 0;
      if (okx) axis_ref(1'b1, tol, maxt, uy, vy, oky);
      exp_ok = okx && oky;
      exp_frames = 0;
      for (int i = 0; i < ux; i++) exp_cmd[exp_frames++] = 8'hD3;
      for (int i = 0; i < uy; i++) exp_cmd[exp_frames++] = 8'h93;
      exp_cmd[exp_frames++] = okx ? 8'h90 : 8'hD0;

      cfg_div = DIV_W'(div); cfg_tol = RES_W'(tol); cfg_max_tries = RETRY_W'(maxt);
      nframes = 0; starts = 0; xi = 0; yi = 0; tail_ones = 0; bad_frames = 0; phase_bad = 0;
      @(negedge clk);
      pen_irq_n = 1'b0;
      guard = 0;
      while (starts == 0 && guard < 100) begin @(negedge clk); guard++; end
      got_v = 0; got_e = 0; gx = '0; gy = '0;
      for (int i = 0; i < 30000; i++) begin
         @(negedge clk);
         if (coord_valid || coord_err) begin
            got_v = coord_valid; got_e = coord_err; gx = x_o; gy = y_o;
            break;
         end
         if (nframes < exp_frames - 1) begin
            if ($urandom % 5 == 0) pen_irq_n = ~pen_irq_n;
         end else begin
            pen_irq_n = 1'b1;
         end
      end
      pen_irq_n = 1'b1;
      s0 = starts;
      repeat (60) @(negedge clk);

      check(got_v == exp_ok && got_e == !exp_ok, {"R8 outcome ", tag}, {got_v, got_e}, {exp_ok, !exp_ok});
      check(got_e == !okx || !okx == 0 && got_e == !oky, {"R7 retry limit outcome ", tag}, got_e, !exp_ok);
      if (exp_ok) begin
         check(gx == RES_W'(vx), {"R6 R4 x value ", tag}, gx, vx);
         check(gy == RES_W'(vy), {"R6 R4 y value ", tag}, gy, vy);
         prev_x = vx; prev_y = vy;
      end else begin
         check(gx == RES_W'(prev_x) && gy == RES_W'(prev_y), {"R9 coords held on error ", tag},
               gx, prev_x);
      end
      check(nframes == exp_frames, {"R8 frame count ", tag}, nframes, exp_frames);
      for (int i = 0; i < exp_frames && i < nframes && i < 32; i++)
         check(cmd_log[i] == exp_cmd[i], {"R3 command byte ", tag}, cmd_log[i], exp_cmd[i]);
      check(tail_ones == 0, {"R3 trailing bytes zero ", tag}, tail_ones, 0);
      check(bad_frames == 0, {"R1 24 rises per frame ", tag}, bad_frames, 0);
      check(phase_bad == 0, {"R2 phase length ", tag}, phase_bad, 0);
      check(starts == s0, {"R5 no restart with pen high ", tag}, starts - s0, 0);
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R10 reset serial pins", {cs_n, sclk, mosi}, 3'b100);
      check(!coord_valid && !coord_err && x_o == '0 && y_o == '0, "R10 reset outputs",
            {coord_valid, coord_err}, 0);
      starts = 0;
      repeat (100) @(negedge clk);
      check(starts == 0 && cs_n, "R5 idle while pen high", starts, 0);

      // exactly-tolerance and tolerance+1 on X, identical readings at full scale on Y
      xs = '{1000, 1005, 1009, 1013, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
      ys = '{4095, 4095, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
      run_trial(1, 4, 6, "tol edge");
      // zero tolerance, zero code
      xs = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
      ys = '{7, 8, 8, 9, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
      run_trial(2, 0, 3, "zero tol");
      // X never settles: error at limit, Y skipped
      xs = '{100, 200, 300, 400, 500, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
      ys = '{50, 50, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
      run_trial(0, 2, 3, "x gives up");
      // limit below 2 behaves as 2
      xs = '{10, 50, 10, 10, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
      run_trial(1, 3, 0, "limit zero");
      // Y gives up on last allowed conversion
      xs = '{2048, 2050, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
      ys = '{0, 100, 200, 300, 400, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
      run_trial(3, 5, 4, "y gives up");

      for (int t = 0; t < 18; t++) begin
         int tol, maxt, div;
         tol  = $urandom % 41;
         maxt = 2 + $urandom % 7;
         div  = $urandom % 3;
         fill_axis(1'b0, $urandom % 4096, $urandom % 4, tol);
         fill_axis(1'b1, $urandom % 4096, $urandom % 4, tol);
         run_trial(div, tol, maxt, "random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule